// File: doc/BRIEF.md
# DHCP Client Control State Machine

This block makes the message-level decisions that let a network endpoint obtain an IPv4 address, keep it and give it back. It does not touch frames. A packet layer below it decodes incoming server messages into a strobe with the message type, transaction ID, address, server identifier and lease time. The block answers through a one-cycle send strobe that carries the type of message to emit, the transaction ID, the IP source address to use, the address being claimed and the server being addressed.

The acquisition starts from a start request. The block broadcasts a discover. It answers a matching offer with a request to that server. The request names the offered address in an option field and always uses 0.0.0.0 as its source. The block adopts the address only when the acknowledgement arrives. A lease timer then runs, built from a prescaler that produces one-second ticks and a seconds counter. Once half the granted lease has elapsed, the block sends a renewal request. If the lease runs out first, the address is dropped and acquisition starts over. A negative acknowledgement, a retry budget that runs out, a release request or a loss of link each return the block to a defined state. Every new transaction takes its ID from a free-running counter, and replies that carry another ID are ignored.

Top module: `dhcp_client_ctrl`

## Requirements
- R1: After reset, addr_valid is 0, own_ip is 0 and tx_valid is 0. No message is sent until start_req is seen while link_up is high.
- R2: start_req, seen while idle with link up, makes tx_valid high in the next cycle with tx_type 1 (discover), tx_src_ip 0 and tx_chosen_ip 0.
- R3: An offer (rx_type 2) whose rx_xid equals the current transaction ID is answered in the next cycle with tx_type 3 (request). That request carries the same tx_xid, tx_chosen_ip equal to rx_addr, tx_server equal to rx_server and tx_src_ip 0.
- R4: addr_valid stays 0 and own_ip stays 0 until a matching acknowledgement (rx_type 5) arrives. In the cycle after it, addr_valid is 1 and own_ip equals the offered address.
- R5: A received message whose rx_xid differs from the current transaction ID changes nothing: no message is sent and addr_valid is unchanged.
- R6: A matching negative acknowledgement (rx_type 6) during a request discards the offer. A discover is sent in the next cycle, and a later acknowledgement is ignored until a new offer has been accepted.
- R7: While an offer or an acknowledgement is awaited and nothing arrives, the pending message is sent again every TIMEOUT_CYC cycles. When a request has been repeated MAX_RETRY times and the next timeout expires, a discover is sent instead.
- R8: The granted lease L is rx_lease limited to MAX_LEASE, and a value of 0 is taken as 1. Seconds are counted in TICKS_PER_SEC clock cycles.
- R9: (L - L/2)*TICKS_PER_SEC + 1 cycles after the acknowledgement, a request (tx_type 3) goes to the bound server with tx_chosen_ip equal to own_ip and tx_src_ip 0. A matching acknowledgement to it restarts the lease and keeps addr_valid at 1.
- R10: If no acknowledgement arrives, addr_valid falls L*TICKS_PER_SEC + 1 cycles after the last acknowledgement, and a discover is sent in that same cycle.
- R11: release_req while the address is held sends tx_type 7 (release) with tx_src_ip equal to the held address and tx_server equal to the bound server. addr_valid drops in the same cycle. The block then stays idle until start_req begins a new acquisition.
- R12: While link_up is low, the next cycle shows addr_valid 0 and own_ip 0, and no message is sent, renewal included, until link returns and start_req is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| link_up | input | 1 | Physical link is present |
| start_req | input | 1 | Begin acquisition from idle |
| release_req | input | 1 | Give the held address back |
| rx_valid | input | 1 | Decoded server message strobe |
| rx_type | input | 3 | Message type code of received message |
| rx_xid | input | XID_W | Transaction ID of received message |
| rx_addr | input | 32 | Address offered or acknowledged |
| rx_server | input | 32 | Server identifier |
| rx_lease | input | 32 | Lease time in seconds |
| tx_valid | output | 1 | Send-message strobe, one cycle |
| tx_type | output | 3 | Message type code to send |
| tx_xid | output | XID_W | Transaction ID to send |
| tx_src_ip | output | 32 | IP source address to use |
| tx_chosen_ip | output | 32 | Requested-address option value |
| tx_server | output | 32 | Server the message is aimed at |
| addr_valid | output | 1 | A leased address is held |
| own_ip | output | 32 | Held address, 0 when none |

## Verification
The bench uses a small configuration: four cycles per second, a 16-cycle timeout, two retries and a 20-second lease limit. In it, every timing rule reduces to an exact cycle count that the bench computes from L. A design that committed the offered address early would show addr_valid or own_ip set after the offer, and one that trusted stale transaction IDs would send messages or take an address from the wrong replies. Lease arithmetic is probed at a lease of zero, where renewal and expiry fall in the same cycle, at an oversized lease that must be clipped, and at a mid-size lease renewed once. An off-by-one tick count or a rounding error in the half lease shifts these times by whole seconds. Retry budgets, release and link loss are driven until the block must fall back, so a design that over-retried, kept renewing on a dead link or kept its address after release would show up in the timing or type of the next message.

// File: rtl/dhcp_ctrl_pkg.sv
package dhcp_ctrl_pkg;

  typedef enum logic [2:0] {
    MSG_NONE     = 3'd0,
    MSG_DISCOVER = 3'd1,
    MSG_OFFER    = 3'd2,
    MSG_REQUEST  = 3'd3,
    MSG_ACK      = 3'd5,
    MSG_NAK      = 3'd6,
    MSG_RELEASE  = 3'd7
  } msg_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SELECT,
    ST_REQUEST,
    ST_BOUND,
    ST_RENEW
  } cstate_e;

endpackage

// File: rtl/dhcp_xid_src.sv
module dhcp_xid_src #(
  parameter int XID_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [XID_W-1:0] xid_free
);

  logic [XID_W-1:0] cnt_q, cnt_d;

  always_comb cnt_d = cnt_q + XID_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign xid_free = cnt_q;

endmodule

// File: rtl/dhcp_wait_timer.sv
module dhcp_wait_timer #(
  parameter int TIMEOUT_CYC = 2_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  output logic timeout
);

  localparam int TO_W = (TIMEOUT_CYC > 1) ? $clog2(TIMEOUT_CYC) : 1;
  localparam logic [TO_W-1:0] LAST = TO_W'(TIMEOUT_CYC - 1);

  logic [TO_W-1:0] cnt_q, cnt_d;
  logic            cnt_en;

  always_comb begin
    cnt_en = 1'b1;
    if (restart || !run) cnt_d = '0;
    else if (cnt_q != LAST) cnt_d = cnt_q + TO_W'(1);
    else begin
      cnt_d  = cnt_q;
      cnt_en = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign timeout = run && (cnt_q == LAST);

  p_timer_bounded_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

endmodule

// File: rtl/dhcp_lease_timer.sv
module dhcp_lease_timer #(
  parameter int TICKS_PER_SEC = 100_000_000,
  parameter int LEASE_W       = 17,
  parameter int MAX_LEASE     = 86400
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load,
  input  logic        clear,
  input  logic [31:0] lease_in,
  output logic        renew_due,
  output logic        expired
);

  localparam int PRE_W = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
  localparam logic [PRE_W-1:0]   PRE_LAST = PRE_W'(TICKS_PER_SEC - 1);
  localparam logic [LEASE_W-1:0] LMAX     = LEASE_W'(MAX_LEASE);

  logic               active_q, active_d;
  logic [PRE_W-1:0]   pre_q, pre_d;
  logic [LEASE_W-1:0] rem_q, rem_d, half_q, half_d, clipped;
  logic               tick;

  always_comb begin
    if (lease_in == 32'd0)                 clipped = LEASE_W'(1);
    else if (lease_in > 32'(MAX_LEASE))    clipped = LMAX;
    else                                   clipped = lease_in[LEASE_W-1:0];
  end

  assign tick = active_q && (pre_q == PRE_LAST);

  always_comb begin
    active_d = active_q;
    pre_d    = pre_q;
    rem_d    = rem_q;
    half_d   = half_q;
    if (clear) begin
      active_d = 1'b0;
      pre_d    = '0;
      rem_d    = '0;
      half_d   = '0;
    end else if (load) begin
      active_d = 1'b1;
      pre_d    = '0;
      rem_d    = clipped;
      half_d   = clipped >> 1;
    end else if (active_q) begin
      pre_d = tick ? '0 : pre_q + PRE_W'(1);
      if (tick && rem_q != '0) rem_d = rem_q - LEASE_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      pre_q    <= '0;
      rem_q    <= '0;
      half_q   <= '0;
    end else begin
      active_q <= active_d;
      pre_q    <= pre_d;
      rem_q    <= rem_d;
      half_q   <= half_d;
    end
  end

  assign expired   = active_q && (rem_q == '0);
  assign renew_due = active_q && (rem_q <= half_q);

  p_rem_bounded_r8: assert property (@(posedge clk) disable iff (!rst_n)
    active_q |-> (rem_q <= LMAX && rem_q != '0 || rem_q == '0 && $past(active_q)));

endmodule

// File: rtl/dhcp_client_ctrl.sv
module dhcp_client_ctrl
  import dhcp_ctrl_pkg::*;
#(
  parameter int XID_W         = 16,
  parameter int TICKS_PER_SEC = 100_000_000,
  parameter int TIMEOUT_CYC   = 2_000_000,
  parameter int MAX_RETRY     = 3,
  parameter int LEASE_W       = 17,
  parameter int MAX_LEASE     = 86400
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             link_up,
  input  logic             start_req,
  input  logic             release_req,
  input  logic             rx_valid,
  input  logic [2:0]       rx_type,
  input  logic [XID_W-1:0] rx_xid,
  input  logic [31:0]      rx_addr,
  input  logic [31:0]      rx_server,
  input  logic [31:0]      rx_lease,
  output logic             tx_valid,
  output logic [2:0]       tx_type,
  output logic [XID_W-1:0] tx_xid,
  output logic [31:0]      tx_src_ip,
  output logic [31:0]      tx_chosen_ip,
  output logic [31:0]      tx_server,
  output logic             addr_valid,
  output logic [31:0]      own_ip
);

  localparam int RTY_W = (MAX_RETRY > 0) ? $clog2(MAX_RETRY + 1) : 1;
  localparam logic [RTY_W-1:0] RTY_LAST = RTY_W'(MAX_RETRY);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       srst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign srst_n = rst_sync_q[1];

  // sub-blocks
  logic [XID_W-1:0] xid_free;
  logic             wait_run, timeout, send;
  logic             lease_load, lease_clear, renew_due, lease_expired;

  dhcp_xid_src #(.XID_W(XID_W)) u_xid (
    .clk(clk), .rst_n(srst_n), .xid_free(xid_free)
  );

  dhcp_wait_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_wait (
    .clk(clk), .rst_n(srst_n), .run(wait_run), .restart(send), .timeout(timeout)
  );

  dhcp_lease_timer #(
    .TICKS_PER_SEC(TICKS_PER_SEC), .LEASE_W(LEASE_W), .MAX_LEASE(MAX_LEASE)
  ) u_lease (
    .clk(clk), .rst_n(srst_n), .load(lease_load), .clear(lease_clear),
    .lease_in(rx_lease), .renew_due(renew_due), .expired(lease_expired)
  );

  // state
  cstate_e          state_q, state_d;
  logic [XID_W-1:0] xid_q, xid_d;
  logic [31:0]      offer_q, offer_d, server_q, server_d, own_q, own_d;
  logic             valid_q, valid_d;
  logic [RTY_W-1:0] retry_q, retry_d;

  // outgoing message
  msg_e        s_type;
  logic [31:0] s_src, s_chosen, s_srv;
  logic        drop, disc;

  logic             tx_valid_q;
  logic [2:0]       tx_type_q;
  logic [XID_W-1:0] tx_xid_q;
  logic [31:0]      tx_src_q, tx_chosen_q, tx_server_q;

  logic rx_ok, rx_offer, rx_ack, rx_nak;
  assign rx_ok    = rx_valid && (rx_xid == xid_q);
  assign rx_offer = rx_ok && (rx_type == MSG_OFFER);
  assign rx_ack   = rx_ok && (rx_type == MSG_ACK);
  assign rx_nak   = rx_ok && (rx_type == MSG_NAK);

  assign wait_run = (state_q == ST_SELECT) || (state_q == ST_REQUEST) ||
                    (state_q == ST_RENEW);

  always_comb begin
    state_d     = state_q;
    xid_d       = xid_q;
    offer_d     = offer_q;
    server_d    = server_q;
    own_d       = own_q;
    valid_d     = valid_q;
    retry_d     = retry_q;
    send        = 1'b0;
    s_type      = MSG_NONE;
    s_src       = '0;
    s_chosen    = '0;
    s_srv       = '0;
    lease_load  = 1'b0;
    lease_clear = 1'b0;
    drop        = 1'b0;
    disc        = 1'b0;

    if (!link_up) begin
      state_d = ST_IDLE;
      drop    = 1'b1;
      retry_d = '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start_req) disc = 1'b1;
        end
        ST_SELECT: begin
          if (rx_offer) begin
            offer_d  = rx_addr;
            server_d = rx_server;
            retry_d  = '0;
            state_d  = ST_REQUEST;
            send     = 1'b1;
            s_type   = MSG_REQUEST;
            s_chosen = rx_addr;
            s_srv    = rx_server;
          end else if (timeout) begin
            disc = 1'b1;
          end
        end
        ST_REQUEST: begin
          if (rx_ack) begin
            own_d      = offer_q;
            valid_d    = 1'b1;
            lease_load = 1'b1;
            state_d    = ST_BOUND;
          end else if (rx_nak) begin
            drop = 1'b1;
            disc = 1'b1;
          end else if (timeout) begin
            if (retry_q == RTY_LAST) begin
              drop = 1'b1;
              disc = 1'b1;
            end else begin
              retry_d  = retry_q + RTY_W'(1);
              send     = 1'b1;
              s_type   = MSG_REQUEST;
              s_chosen = offer_q;
              s_srv    = server_q;
            end
          end
        end
        ST_BOUND, ST_RENEW: begin
          if (release_req) begin
            send    = 1'b1;
            s_type  = MSG_RELEASE;
            s_src   = own_q;
            s_srv   = server_q;
            drop    = 1'b1;
            state_d = ST_IDLE;
          end else if (lease_expired || rx_nak) begin
            drop = 1'b1;
            disc = 1'b1;
          end else if (state_q == ST_RENEW && rx_ack) begin
            lease_load = 1'b1;
            state_d    = ST_BOUND;
          end else if ((state_q == ST_BOUND && renew_due) ||
                       (state_q == ST_RENEW && timeout)) begin
            if (state_q == ST_BOUND) xid_d = xid_free;
            state_d  = ST_RENEW;
            send     = 1'b1;
            s_type   = MSG_REQUEST;
            s_chosen = own_q;
            s_srv    = server_q;
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end

    if (drop) begin
      valid_d     = 1'b0;
      own_d       = '0;
      offer_d     = '0;
      server_d    = '0;
      lease_clear = 1'b1;
    end
    if (disc) begin
      state_d  = ST_SELECT;
      xid_d    = xid_free;
      retry_d  = '0;
      send     = 1'b1;
      s_type   = MSG_DISCOVER;
      s_src    = '0;
      s_chosen = '0;
      s_srv    = '0;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      state_q  <= ST_IDLE;
      xid_q    <= '0;
      offer_q  <= '0;
      server_q <= '0;
      own_q    <= '0;
      valid_q  <= 1'b0;
      retry_q  <= '0;
    end else begin
      state_q  <= state_d;
      xid_q    <= xid_d;
      offer_q  <= offer_d;
      server_q <= server_d;
      own_q    <= own_d;
      valid_q  <= valid_d;
      retry_q  <= retry_d;
    end
  end

  // message fields load only when a message goes out
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      tx_valid_q  <= 1'b0;
      tx_type_q   <= '0;
      tx_xid_q    <= '0;
      tx_src_q    <= '0;
      tx_chosen_q <= '0;
      tx_server_q <= '0;
    end else begin
      tx_valid_q <= send;
      if (send) begin
        tx_type_q   <= s_type;
        tx_xid_q    <= xid_d;
        tx_src_q    <= s_src;
        tx_chosen_q <= s_chosen;
        tx_server_q <= s_srv;
      end
    end
  end

  assign tx_valid     = tx_valid_q;
  assign tx_type      = tx_type_q;
  assign tx_xid       = tx_xid_q;
  assign tx_src_ip    = tx_src_q;
  assign tx_chosen_ip = tx_chosen_q;
  assign tx_server    = tx_server_q;
  assign addr_valid   = valid_q;
  assign own_ip       = own_q;

  p_commit_after_ack_r4: assert property (@(posedge clk) disable iff (!srst_n)
    $rose(valid_q) |-> $past(rx_valid && rx_type == MSG_ACK && link_up));

  p_no_addr_when_invalid_r4: assert property (@(posedge clk) disable iff (!srst_n)
    !valid_q |-> own_q == 32'd0);

  p_request_from_zero_r3: assert property (@(posedge clk) disable iff (!srst_n)
    (tx_valid_q && tx_type_q == MSG_REQUEST) |-> tx_src_q == 32'd0);

  p_link_down_quiet_r12: assert property (@(posedge clk) disable iff (!srst_n)
    !link_up |=> (!valid_q && !tx_valid_q));

  p_release_only_held_r11: assert property (@(posedge clk) disable iff (!srst_n)
    (tx_valid_q && tx_type_q == MSG_RELEASE) |-> $past(valid_q));

endmodule

// File: tb/sim_dhcp_client_ctrl.sv
module sim_dhcp_client_ctrl;

  localparam int XW = 8;
  localparam int TPS = 4;
  localparam int TO = 16;
  localparam int MR = 2;
  localparam int LW = 5;
  localparam int ML = 20;

  localparam logic [2:0] T_DISC = 3'd1, T_OFFER = 3'd2, T_REQ = 3'd3,
                         T_ACK = 3'd5, T_NAK = 3'd6, T_REL = 3'd7;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n, link_up, start_req, release_req, rx_valid;
  logic [2:0]    rx_type;
  logic [XW-1:0] rx_xid;
  logic [31:0]   rx_addr, rx_server, rx_lease;
  logic          tx_valid, addr_valid;
  logic [2:0]    tx_type;
  logic [XW-1:0] tx_xid;
  logic [31:0]   tx_src_ip, tx_chosen_ip, tx_server, own_ip;

  dhcp_client_ctrl #(
    .XID_W(XW), .TICKS_PER_SEC(TPS), .TIMEOUT_CYC(TO), .MAX_RETRY(MR),
    .LEASE_W(LW), .MAX_LEASE(ML)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .link_up(link_up), .start_req(start_req),
    .release_req(release_req), .rx_valid(rx_valid), .rx_type(rx_type),
    .rx_xid(rx_xid), .rx_addr(rx_addr), .rx_server(rx_server), .rx_lease(rx_lease),
    .tx_valid(tx_valid), .tx_type(tx_type), .tx_xid(tx_xid), .tx_src_ip(tx_src_ip),
    .tx_chosen_ip(tx_chosen_ip), .tx_server(tx_server), .addr_valid(addr_valid),
    .own_ip(own_ip)
  );

  int vectors = 0;
  int miscompares = 0;
  logic done = 1'b0;
  logic [XW-1:0] cur_xid = '0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    if (tx_valid) cur_xid = tx_xid;
  endtask

  task automatic rx(input logic [2:0] t, input logic [XW-1:0] x,
                    input logic [31:0] a, input logic [31:0] s, input logic [31:0] l);
    rx_valid = 1'b1; rx_type = t; rx_xid = x;
    rx_addr = a; rx_server = s; rx_lease = l;
    step();
    rx_valid = 1'b0;
  endtask

  task automatic wait_tx(output int n);
    n = 0;
    do begin
      step();
      n++;
    end while (!tx_valid && n < 300);
  endtask

  task automatic lease_run(output int t_tx, output int t_drop);
    t_tx = 0;
    t_drop = 0;
    for (int n = 1; n <= 300; n++) begin
      step();
      if (tx_valid && t_tx == 0) t_tx = n;
      if (!addr_valid) begin
        t_drop = n;
        break;
      end
    end
  endtask

  task automatic count_tx(input int cycles, output int cnt);
    cnt = 0;
    for (int i = 0; i < cycles; i++) begin
      step();
      if (tx_valid) cnt++;
    end
  endtask

  task automatic start();
    start_req = 1'b1;
    step();
    start_req = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    int n, t_tx, t_drop, cnt;
    logic [XW-1:0] x0;
    rst_n = 1'b0; link_up = 1'b1; start_req = 1'b0; release_req = 1'b0;
    rx_valid = 1'b0; rx_type = '0; rx_xid = '0;
    rx_addr = '0; rx_server = '0; rx_lease = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) step();

    // R1 reset state and silence while idle
    chk("R1 addr_valid", {31'd0, addr_valid}, 32'd0);
    chk("R1 own_ip", own_ip, 32'd0);
    chk("R1 tx_valid", {31'd0, tx_valid}, 32'd0);
    count_tx(12, cnt);
    chk("R1 idle tx count", cnt, 0);

    // R2 discover
    start();
    chk("R2 tx_valid", {31'd0, tx_valid}, 32'd1);
    chk("R2 type", {29'd0, tx_type}, {29'd0, T_DISC});
    chk("R2 src", tx_src_ip, 32'd0);
    chk("R2 chosen", tx_chosen_ip, 32'd0);
    x0 = cur_xid;

    // R5 offer with wrong id
    rx(T_OFFER, x0 ^ 8'h01, 32'h0A000105, 32'h0A000001, 0);
    chk("R5 wrong-id offer tx", {31'd0, tx_valid}, 32'd0);

    // R3 offer answered by request
    rx(T_OFFER, x0, 32'h0A000105, 32'h0A000001, 0);
    chk("R3 tx_valid", {31'd0, tx_valid}, 32'd1);
    chk("R3 type", {29'd0, tx_type}, {29'd0, T_REQ});
    chk("R3 chosen", tx_chosen_ip, 32'h0A000105);
    chk("R3 server", tx_server, 32'h0A000001);
    chk("R3 src", tx_src_ip, 32'd0);
    chk("R3 xid", {24'd0, tx_xid}, {24'd0, x0});
    chk("R4 not valid before ack", {31'd0, addr_valid}, 32'd0);
    chk("R4 own_ip before ack", own_ip, 32'd0);

    // R5 wrong-id ack ignored
    rx(T_ACK, x0 ^ 8'h80, 32'h0A000105, 32'h0A000001, 10);
    chk("R5 wrong-id ack addr_valid", {31'd0, addr_valid}, 32'd0);

    // R4 commit on ack, R9 renewal at half lease
    rx(T_ACK, x0, 32'h0A000105, 32'h0A000001, 10);
    chk("R4 addr_valid", {31'd0, addr_valid}, 32'd1);
    chk("R4 own_ip", own_ip, 32'h0A000105);
    wait_tx(n);
    chk("R9 renew time", n, (10 - 10/2) * TPS + 1);
    chk("R9 type", {29'd0, tx_type}, {29'd0, T_REQ});
    chk("R9 chosen", tx_chosen_ip, 32'h0A000105);
    chk("R9 server", tx_server, 32'h0A000001);
    chk("R9 src", tx_src_ip, 32'd0);
    rx(T_ACK, cur_xid, 32'h0A000105, 32'h0A000001, 6);
    chk("R9 still valid after renew ack", {31'd0, addr_valid}, 32'd1);

    // R10 expiry without answer
    lease_run(t_tx, t_drop);
    chk("R9 second renew time", t_tx, (6 - 6/2) * TPS + 1);
    chk("R10 expiry time", t_drop, 6 * TPS + 1);
    chk("R10 discover on expiry", {29'd0, tx_type}, {29'd0, T_DISC});
    chk("R10 own_ip cleared", own_ip, 32'd0);

    // R7 retransmission and fallback
    wait_tx(n);
    chk("R7 discover repeat gap", n, TO);
    chk("R7 discover repeat type", {29'd0, tx_type}, {29'd0, T_DISC});
    rx(T_OFFER, cur_xid, 32'h0A000107, 32'h0A000002, 0);
    chk("R3 request after repeat", {29'd0, tx_type}, {29'd0, T_REQ});
    for (int k = 0; k < MR; k++) begin
      wait_tx(n);
      chk("R7 request repeat gap", n, TO);
      chk("R7 request repeat type", {29'd0, tx_type}, {29'd0, T_REQ});
      chk("R7 request repeat chosen", tx_chosen_ip, 32'h0A000107);
    end
    wait_tx(n);
    chk("R7 fallback gap", n, TO);
    chk("R7 fallback type", {29'd0, tx_type}, {29'd0, T_DISC});

    // R6 negative acknowledgement
    rx(T_OFFER, cur_xid, 32'h0A000108, 32'h0A000003, 0);
    x0 = cur_xid;
    rx(T_NAK, x0 ^ 8'h04, 0, 32'h0A000003, 0);
    chk("R5 wrong-id nak tx", {31'd0, tx_valid}, 32'd0);
    rx(T_NAK, x0, 0, 32'h0A000003, 0);
    chk("R6 discover after nak", {29'd0, tx_type}, {29'd0, T_DISC});
    chk("R6 tx_valid", {31'd0, tx_valid}, 32'd1);
    rx(T_ACK, cur_xid, 32'h0A000108, 32'h0A000003, 10);
    chk("R6 ack without offer ignored", {31'd0, addr_valid}, 32'd0);
    chk("R6 own_ip", own_ip, 32'd0);

    // R8 zero lease taken as one second
    rx(T_OFFER, cur_xid, 32'h0A000109, 32'h0A000003, 0);
    rx(T_ACK, cur_xid, 32'h0A000109, 32'h0A000003, 0);
    chk("R8 valid with zero lease", {31'd0, addr_valid}, 32'd1);
    lease_run(t_tx, t_drop);
    chk("R8 zero lease drop time", t_drop, 1 * TPS + 1);
    chk("R8 zero lease tx time", t_tx, 1 * TPS + 1);
    chk("R8 zero lease tx type", {29'd0, tx_type}, {29'd0, T_DISC});

    // R8 oversized lease clipped
    rx(T_OFFER, cur_xid, 32'h0A00010C, 32'h0A000004, 0);
    rx(T_ACK, cur_xid, 32'h0A00010C, 32'h0A000004, 1000);
    wait_tx(n);
    chk("R8 clipped renew time", n, (ML - ML/2) * TPS + 1);
    chk("R9 clipped renew chosen", tx_chosen_ip, 32'h0A00010C);
    rx(T_ACK, cur_xid, 32'h0A00010C, 32'h0A000004, 20);

    // R11 release
    release_req = 1'b1;
    step();
    release_req = 1'b0;
    chk("R11 release sent", {31'd0, tx_valid}, 32'd1);
    chk("R11 type", {29'd0, tx_type}, {29'd0, T_REL});
    chk("R11 src", tx_src_ip, 32'h0A00010C);
    chk("R11 server", tx_server, 32'h0A000004);
    chk("R11 addr_valid", {31'd0, addr_valid}, 32'd0);
    chk("R11 own_ip", own_ip, 32'd0);
    count_tx(100, cnt);
    chk("R11 silent after release", cnt, 0);
    start();
    chk("R11 reacquire discover", {29'd0, tx_type}, {29'd0, T_DISC});

    // R12 link loss
    rx(T_OFFER, cur_xid, 32'h0A00010D, 32'h0A000005, 0);
    rx(T_ACK, cur_xid, 32'h0A00010D, 32'h0A000005, 10);
    chk("R4 bound before link loss", {31'd0, addr_valid}, 32'd1);
    link_up = 1'b0;
    step();
    chk("R12 addr_valid", {31'd0, addr_valid}, 32'd0);
    chk("R12 own_ip", own_ip, 32'd0);
    chk("R12 tx_valid", {31'd0, tx_valid}, 32'd0);
    start();
    count_tx(100, cnt);
    chk("R12 no renew on lost link", cnt + (tx_valid ? 1 : 0), 0);
    link_up = 1'b1;
    count_tx(5, cnt);
    chk("R12 idle after link returns", cnt, 0);
    start();
    chk("R12 discover after link returns", {29'd0, tx_type}, {29'd0, T_DISC});

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule